// File: doc/BRIEF.md
# USB line-state event detector

This block watches the two data lines of a USB port (D+ and D-) using a free-running system clock of known frequency. It passes both lines through a synchronizer and sorts every sample into one of four line states: J, K, single-ended zero (SE0) or single-ended one (SE1). The J and K polarity comes from a speed-select input. The current line state is always available as a level output.

A single run-length counter measures how long the current line state has lasted. The counter restarts whenever the state changes. Comparing that length against thresholds produces one-cycle pulses for five bus conditions: device connect, disconnect, bus reset, suspend, and resume signalling. A separate pulse marks every SE1 sample, because SE1 is an illegal state. Each threshold is worked out at elaboration from the clock frequency and a duration given in nanoseconds, so the same code serves any system clock.

A link-layer controller uses these pulses to move between attached, reset, suspended and running states. It does not need to time the lines itself.

Top module: `usb_line_event_det`

## Requirements
- R1: `line_state_o` shows the class of the D+/D- pair sampled two clock edges earlier, encoded as SE0 = 0, J = 1, K = 2, SE1 = 3. Both lines low is SE0 and both lines high is SE1, at either speed.
- R2: With `full_speed_i` = 1, D+ high with D- low is J, and D+ low with D- high is K.
- R3: With `full_speed_i` = 0 the polarity is reversed: D+ low with D- high is J, and D+ high with D- low is K.
- R4: Every SE1 sample raises `se1_err_o` for one cycle. An SE1 sample ends any J, K or SE0 run, so the counting for that state starts again afterwards.
- R5: When `line_state_o` has shown J for the connect threshold of consecutive samples (2.5 µs) and the block is not attached, `connect_o` pulses and the block becomes attached. No further connect pulse occurs until a disconnect.
- R6: When SE0 reaches the disconnect threshold (2 µs), `disconnect_o` pulses once for that SE0 period and the block leaves the attached condition. A shorter SE0 gives no pulse.
- R7: When the same SE0 period reaches the bus-reset threshold (10 ms), `bus_reset_o` pulses once. The disconnect pulse of that period comes earlier.
- R8: When J reaches the suspend threshold (3 ms of idle), `suspend_o` pulses once for that idle period.
- R9: A K period of at least the resume threshold (20 ms), followed by one or more SE0 samples and then a J sample, pulses `resume_o` once. The pulse follows the first J sample. A shorter K, or a K that is not followed by SE0, gives no pulse.
- R10: Each threshold in clock cycles is the duration multiplied by `CLK_HZ`, rounded up. A pulse is high in the cycle after the one in which `line_state_o` first shows the last sample needed.
- R11: After reset all pulses are low and `line_state_o` is SE0. Samples are counted only once the synchronizer holds real line data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | D+ receiver output, asynchronous |
| dm_i | input | 1 | D- receiver output, asynchronous |
| full_speed_i | input | 1 | 1 selects full-speed polarity, 0 selects low-speed polarity |
| line_state_o | output | 2 | Current classified line state |
| connect_o | output | 1 | Connect pulse |
| disconnect_o | output | 1 | Disconnect pulse |
| bus_reset_o | output | 1 | Bus reset pulse |
| suspend_o | output | 1 | Suspend pulse |
| resume_o | output | 1 | Resume pulse |
| se1_err_o | output | 1 | Illegal SE1 sample pulse |

## Verification
The embedded properties assume that the disconnect threshold is shorter than the bus-reset threshold. They also assume that `full_speed_i` is a quasi-static setting, so any change to it is simply treated as a line-state change. The bench changes the speed select only once, between two stimulus phases, and it always holds the data lines for whole clock cycles. The bench sets the clock-frequency parameter to 1 MHz so that the millisecond thresholds become a few thousand cycles. Each timed condition is then driven exactly at its threshold, one sample short of it, and well beyond it.

// File: rtl/usb_lsd_pkg.sv
`timescale 1ns/1ps
package usb_lsd_pkg;

   typedef enum logic [1:0] {
      LS_SE0 = 2'd0,
      LS_J   = 2'd1,
      LS_K   = 2'd2,
      LS_SE1 = 2'd3
   } line_t;

   typedef struct packed {
      logic connect;
      logic disconnect;
      logic bus_reset;
      logic suspend;
      logic se1_err;
   } evt_t;

   // cycles needed to cover a duration, rounded up
   function automatic int unsigned ns_to_cycles(input int unsigned hz, input int unsigned ns);
      longint unsigned prod;
      prod = 64'(hz) * 64'(ns);
      return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/usb_lsd_sync.sv
`timescale 1ns/1ps
module usb_lsd_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic             valid_o
);

   logic [STAGES-1:0][WIDTH-1:0] stage_q;
   logic [STAGES-1:0]            fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         fill_q  <= '0;
      end else begin
         stage_q <= {stage_q[STAGES-2:0], d_i};
         fill_q  <= {fill_q[STAGES-2:0], 1'b1};
      end
   end

   assign q_o     = stage_q[STAGES-1];
   assign valid_o = fill_q[STAGES-1];

   // R11
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> valid_o);

endmodule

// File: rtl/usb_lsd_classify.sv
`timescale 1ns/1ps
module usb_lsd_classify
   import usb_lsd_pkg::*;
(
   input  logic [1:0] pair_i,      // {D+, D-}
   input  logic       full_speed_i,
   output line_t      cls_o
);

   always_comb begin
      unique case (pair_i)
         2'b00:   cls_o = LS_SE0;
         2'b11:   cls_o = LS_SE1;
         2'b10:   cls_o = full_speed_i ? LS_J : LS_K;
         default: cls_o = full_speed_i ? LS_K : LS_J;
      endcase
   end

endmodule

// File: rtl/usb_lsd_runtimer.sv
`timescale 1ns/1ps
module usb_lsd_runtimer
   import usb_lsd_pkg::*;
#(
   parameter int unsigned TH_CONN   = 3,
   parameter int unsigned TH_DISC   = 2,
   parameter int unsigned TH_RST    = 10,
   parameter int unsigned TH_SUSP   = 6,
   parameter int unsigned SAT_LIMIT = 11,
   parameter int unsigned CW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  line_t         cls_i,
   output logic [CW-1:0] dur_o,
   output evt_t          evt_o
);

   localparam logic [CW-1:0] SAT    = CW'(SAT_LIMIT);
   localparam logic [CW-1:0] LIM_CN = CW'(TH_CONN);
   localparam logic [CW-1:0] LIM_DC = CW'(TH_DISC);
   localparam logic [CW-1:0] LIM_RS = CW'(TH_RST);
   localparam logic [CW-1:0] LIM_SP = CW'(TH_SUSP);

   line_t         prev_q;
   logic [CW-1:0] cnt_q;
   logic          attached_q;
   evt_t          evt_q;
   logic          hit_conn, hit_disc, hit_rst, hit_susp;

   // run length including the present sample; saturates past every limit
   always_comb begin
      if (cnt_q != '0 && cls_i == prev_q) begin
         dur_o = (cnt_q == SAT) ? SAT : cnt_q + 1'b1;
      end else begin
         dur_o = CW'(1);
      end
   end

   assign hit_conn = (cls_i == LS_J)   && (dur_o == LIM_CN) && !attached_q;
   assign hit_disc = (cls_i == LS_SE0) && (dur_o == LIM_DC);
   assign hit_rst  = (cls_i == LS_SE0) && (dur_o == LIM_RS);
   assign hit_susp = (cls_i == LS_J)   && (dur_o == LIM_SP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= LS_SE0;
         cnt_q      <= '0;
         attached_q <= 1'b0;
         evt_q      <= '0;
      end else begin
         evt_q <= '0;
         if (valid_i) begin
            prev_q           <= cls_i;
            cnt_q            <= dur_o;
            evt_q.connect    <= hit_conn;
            evt_q.disconnect <= hit_disc;
            evt_q.bus_reset  <= hit_rst;
            evt_q.suspend    <= hit_susp;
            evt_q.se1_err    <= (cls_i == LS_SE1);
            if (hit_disc) begin
               attached_q <= 1'b0;
            end else if (hit_conn) begin
               attached_q <= 1'b1;
            end
         end
      end
   end

   assign evt_o = evt_q;

   // R5
   conn_unattached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q.connect |-> !$past(attached_q));

   // R6
   disc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q.disconnect |=> !evt_q.disconnect);

   // R7
   rst_from_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q.bus_reset |-> $past(cls_i == LS_SE0));

   // R4
   se1_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q.se1_err |-> $past(cls_i == LS_SE1));

endmodule

// File: rtl/usb_lsd_resume_fsm.sv
`timescale 1ns/1ps
module usb_lsd_resume_fsm
   import usb_lsd_pkg::*;
#(
   parameter int unsigned TH_RES = 20,
   parameter int unsigned CW     = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  line_t         cls_i,
   input  logic [CW-1:0] dur_i,
   output logic          resume_o
);

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_KLONG = 2'd1,
      RS_WAIT  = 2'd2
   } rs_t;

   localparam logic [CW-1:0] LIM_K = CW'(TH_RES);

   rs_t  st_q, st_nxt;
   logic fire, res_q;

   always_comb begin
      st_nxt = st_q;
      fire   = 1'b0;
      unique case (st_q)
         RS_IDLE: begin
            if (cls_i == LS_K && dur_i >= LIM_K) st_nxt = RS_KLONG;
         end
         RS_KLONG: begin
            if (cls_i == LS_SE0)     st_nxt = RS_WAIT;
            else if (cls_i != LS_K)  st_nxt = RS_IDLE;
         end
         RS_WAIT: begin
            if (cls_i == LS_J) begin
               fire   = 1'b1;
               st_nxt = RS_IDLE;
            end else if (cls_i != LS_SE0) begin
               st_nxt = RS_IDLE;
            end
         end
         default: st_nxt = RS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RS_IDLE;
         res_q <= 1'b0;
      end else begin
         res_q <= valid_i & fire;
         if (valid_i) st_q <= st_nxt;
      end
   end

   assign resume_o = res_q;

   // R9
   wait_after_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RS_WAIT) |-> ($past(st_q) == RS_KLONG || $past(st_q) == RS_WAIT));

   // R9
   resume_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_q |-> ($past(st_q) == RS_WAIT && st_q == RS_IDLE));

endmodule

// File: rtl/usb_line_event_det.sv
`timescale 1ns/1ps
module usb_line_event_det
   import usb_lsd_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 48_000_000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CONNECT_NS  = 2_500,
   parameter int unsigned DISCONN_NS  = 2_000,
   parameter int unsigned BUSRST_NS   = 10_000_000,
   parameter int unsigned SUSPEND_NS  = 3_000_000,
   parameter int unsigned RESUME_NS   = 20_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dp_i,
   input  logic       dm_i,
   input  logic       full_speed_i,
   output logic [1:0] line_state_o,
   output logic       connect_o,
   output logic       disconnect_o,
   output logic       bus_reset_o,
   output logic       suspend_o,
   output logic       resume_o,
   output logic       se1_err_o
);

   localparam int unsigned TH_CONN   = ns_to_cycles(CLK_HZ, CONNECT_NS);
   localparam int unsigned TH_DISC   = ns_to_cycles(CLK_HZ, DISCONN_NS);
   localparam int unsigned TH_RST    = ns_to_cycles(CLK_HZ, BUSRST_NS);
   localparam int unsigned TH_SUSP   = ns_to_cycles(CLK_HZ, SUSPEND_NS);
   localparam int unsigned TH_RES    = ns_to_cycles(CLK_HZ, RESUME_NS);
   localparam int unsigned SAT_LIMIT =
      umax(umax(umax(TH_CONN, TH_DISC), umax(TH_RST, TH_SUSP)), TH_RES) + 1;
   localparam int unsigned CW        = $clog2(SAT_LIMIT + 1);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("usb_line_event_det: SYNC_STAGES must be at least 2");
   end
   if (TH_DISC < 1 || TH_CONN < 1 || TH_SUSP < 1 || TH_RES < 1) begin : g_bad_th
      $error("usb_line_event_det: CLK_HZ too low for a threshold");
   end
   if (TH_DISC >= TH_RST) begin : g_bad_order
      $error("usb_line_event_det: disconnect limit must be below bus-reset limit");
   end

   logic [1:0]    pair_s;
   logic          valid_s;
   line_t         cls;
   logic [CW-1:0] dur;
   evt_t          evt;

   usb_lsd_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (2)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_i     ({dp_i, dm_i}),
      .q_o     (pair_s),
      .valid_o (valid_s)
   );

   usb_lsd_classify u_cls (
      .pair_i       (pair_s),
      .full_speed_i (full_speed_i),
      .cls_o        (cls)
   );

   usb_lsd_runtimer #(
      .TH_CONN   (TH_CONN),
      .TH_DISC   (TH_DISC),
      .TH_RST    (TH_RST),
      .TH_SUSP   (TH_SUSP),
      .SAT_LIMIT (SAT_LIMIT),
      .CW        (CW)
   ) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (valid_s),
      .cls_i   (cls),
      .dur_o   (dur),
      .evt_o   (evt)
   );

   usb_lsd_resume_fsm #(
      .TH_RES (TH_RES),
      .CW     (CW)
   ) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (valid_s),
      .cls_i    (cls),
      .dur_i    (dur),
      .resume_o (resume_o)
   );

   assign line_state_o = cls;
   assign connect_o    = evt.connect;
   assign disconnect_o = evt.disconnect;
   assign bus_reset_o  = evt.bus_reset;
   assign suspend_o    = evt.suspend;
   assign se1_err_o    = evt.se1_err;

   // R7
   rst_disc_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_reset_o && disconnect_o));

endmodule

// File: tb/tb_usb_line_event_det.sv
`timescale 1ns/1ps
module tb_usb_line_event_det;

   // thresholds in cycles for a 1 MHz rate, rounded up by hand
   localparam int TH_C = 3;
   localparam int TH_D = 2;
   localparam int TH_R = 10000;
   localparam int TH_S = 3000;
   localparam int TH_K = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dp = 1'b0, dm = 1'b0, fs = 1'b1;
   logic [1:0] line_state_o;
   logic connect_o, disconnect_o, bus_reset_o, suspend_o, resume_o, se1_err_o;

   always #2.5 clk = ~clk;

   usb_line_event_det #(.CLK_HZ(1_000_000)) dut (
      .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .full_speed_i(fs),
      .line_state_o(line_state_o), .connect_o(connect_o),
      .disconnect_o(disconnect_o), .bus_reset_o(bus_reset_o),
      .suspend_o(suspend_o), .resume_o(resume_o), .se1_err_o(se1_err_o)
   );

   int n_tests = 0, n_fail = 0;
   int cyc = 0;
   bit cmp_on = 0;
   int c_conn = 0, c_disc = 0, c_rst = 0, c_susp = 0, c_res = 0, c_err = 0;

   function automatic int cls_of(logic [1:0] pm, logic f);
      case (pm)
         2'b00:   return 0;
         2'b11:   return 3;
         2'b10:   return f ? 1 : 2;
         default: return f ? 2 : 1;
      endcase
   endfunction

   // behavioural reference model
   logic [1:0] sq[$];
   logic [1:0] m_raw;
   int edges, m_prev, m_run, h1c, h1l, h2c, h2l;
   bit m_valid, attached;
   bit e_conn, e_disc, e_rst, e_susp, e_res, e_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         sq.delete(); sq.push_back(2'b00);
         m_raw = 2'b00; edges = 0; m_valid = 0;
         m_prev = -1; m_run = 0; attached = 0;
         h1c = -1; h1l = 0; h2c = -1; h2l = 0;
         {e_conn, e_disc, e_rst, e_susp, e_res, e_err} = '0;
      end else begin
         int c;
         {e_conn, e_disc, e_rst, e_susp, e_res, e_err} = '0;
         if (m_valid) begin
            c = cls_of(m_raw, fs);
            if (c == m_prev) m_run++;
            else begin
               h2c = h1c; h2l = h1l; h1c = m_prev; h1l = m_run;
               m_prev = c; m_run = 1;
            end
            e_conn = (c == 1) && (m_run == TH_C) && !attached;
            e_disc = (c == 0) && (m_run == TH_D);
            if (e_disc) attached = 0; else if (e_conn) attached = 1;
            e_rst  = (c == 0) && (m_run == TH_R);
            e_susp = (c == 1) && (m_run == TH_S);
            e_err  = (c == 3);
            e_res  = (c == 1) && (m_run == 1) && (h1c == 0) && (h2c == 2) && (h2l >= TH_K);
         end
         m_raw = sq.pop_front();
         sq.push_back({dp, dm});
         if (edges < 2) edges++;
         m_valid = (edges >= 2);
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (cmp_on) begin
         int el;
         bit bad;
         el = cls_of(m_raw, fs);
         bad = 0;
         n_tests++;
         if (line_state_o !== 2'(el)) begin bad = 1;
            $display("FAIL R1 line_state cyc %0d got %0d exp %0d", cyc, line_state_o, el); end
         if (connect_o !== e_conn) begin bad = 1;
            $display("FAIL R5 connect cyc %0d got %0b exp %0b", cyc, connect_o, e_conn); end
         if (disconnect_o !== e_disc) begin bad = 1;
            $display("FAIL R6 disconnect cyc %0d got %0b exp %0b", cyc, disconnect_o, e_disc); end
         if (bus_reset_o !== e_rst) begin bad = 1;
            $display("FAIL R7 bus_reset cyc %0d got %0b exp %0b", cyc, bus_reset_o, e_rst); end
         if (suspend_o !== e_susp) begin bad = 1;
            $display("FAIL R8 suspend cyc %0d got %0b exp %0b", cyc, suspend_o, e_susp); end
         if (resume_o !== e_res) begin bad = 1;
            $display("FAIL R9 resume cyc %0d got %0b exp %0b", cyc, resume_o, e_res); end
         if (se1_err_o !== e_err) begin bad = 1;
            $display("FAIL R4 se1_err cyc %0d got %0b exp %0b", cyc, se1_err_o, e_err); end
         if (bad) n_fail++;
         c_conn += int'(connect_o);  c_disc += int'(disconnect_o);
         c_rst  += int'(bus_reset_o); c_susp += int'(suspend_o);
         c_res  += int'(resume_o);   c_err  += int'(se1_err_o);
      end
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d (got running, exp finished)", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input int got, input int want);
      n_tests++;
      if (got != want) begin
         n_fail++;
         $display("FAIL %s got %0d exp %0d", tag, got, want);
      end
   endtask

   task automatic drive(input logic p, input logic m, input int n);
      repeat (n) begin
         @(negedge clk); #1;
         dp = p; dm = m;
      end
   endtask

   int s_conn, s_disc, s_rst, s_susp, s_res, s_err;
   task automatic snap();
      s_conn = c_conn; s_disc = c_disc; s_rst = c_rst;
      s_susp = c_susp; s_res = c_res; s_err = c_err;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1; rst_n = 1'b1; dp = 1'b1; dm = 1'b0;
      @(negedge clk);
      cmp_on = 1;
      #1;
      // R11 reset state
      chk("R11 line_state after reset", int'(line_state_o), 0);
      chk("R11 pulses after reset",
          int'({connect_o, disconnect_o, bus_reset_o, suspend_o, resume_o, se1_err_o}), 0);

      // R5 first idle gives one connect
      snap();
      drive(1, 0, 40);
      chk("R5 connect count", c_conn - s_conn, 1);
      chk("R2 FS J encoding", int'(line_state_o), 1);
      drive(0, 1, 4);
      chk("R2 FS K encoding", int'(line_state_o), 2);

      // R6 R10 traffic with one-sample SE0, then two-sample SE0
      snap();
      for (int i = 0; i < 20; i++) begin
         drive(0, 1, 1); drive(1, 0, 1); drive(0, 1, 2); drive(1, 0, 1);
      end
      drive(0, 0, 1); drive(1, 0, 6);
      chk("R6 short SE0 disconnect count", c_disc - s_disc, 0);
      chk("R5 no reconnect while attached", c_conn - s_conn, 0);
      drive(0, 0, 2); drive(1, 0, 10);
      chk("R6 SE0 at limit disconnect count", c_disc - s_disc, 1);
      chk("R5 reconnect after disconnect", c_conn - s_conn, 1);

      // R1 latency and R4 SE1 handling
      snap();
      @(negedge clk); #1; dp = 1; dm = 1;
      @(negedge clk); #1;
      chk("R1 line_state one edge after SE1", int'(line_state_o), 1);
      dp = 1; dm = 0;
      @(negedge clk); #1;
      chk("R1 line_state two edges after SE1", int'(line_state_o), 3);
      drive(1, 0, 2000);
      drive(1, 1, 2);
      drive(1, 0, 2000);
      chk("R4 SE1 restarts idle run, no suspend", c_susp - s_susp, 0);
      chk("R4 SE1 error pulses", c_err - s_err, 3);
      drive(1, 0, 4000);
      chk("R8 one suspend per idle period", c_susp - s_susp, 1);

      // R9 resume with K exactly at the limit
      snap();
      drive(0, 1, TH_K); drive(0, 0, 3); drive(1, 0, 10);
      chk("R9 resume at K limit", c_res - s_res, 1);
      chk("R6 SE0 in resume sequence", c_disc - s_disc, 1);

      // R9 K one sample short
      snap();
      drive(0, 1, TH_K - 1); drive(0, 0, 3); drive(1, 0, 10);
      chk("R9 short K gives no resume", c_res - s_res, 0);

      // R9 long K straight to J
      snap();
      drive(0, 1, TH_K + 10); drive(1, 0, 10);
      chk("R9 K without SE0 gives no resume", c_res - s_res, 0);

      // R7 long SE0
      snap();
      drive(0, 0, TH_R + 5); drive(1, 0, 10);
      chk("R7 bus reset count", c_rst - s_rst, 1);
      chk("R6 disconnect once in long SE0", c_disc - s_disc, 1);
      chk("R5 connect after reset idle", c_conn - s_conn, 1);

      // R3 low-speed polarity
      snap();
      drive(0, 1, 1); #0 fs = 1'b0;
      drive(0, 1, TH_S + 5);
      chk("R3 LS J encoding", int'(line_state_o), 1);
      chk("R3 LS idle reaches suspend", c_susp - s_susp, 1);
      drive(1, 0, 4);
      chk("R3 LS K encoding", int'(line_state_o), 2);
      drive(0, 1, 5);

      cmp_on = 0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule